// File: doc/BRIEF.md
# Multi-Channel Packet DMA Engine

This block moves data between a word-wide memory bus and a set of per-endpoint packet FIFOs on behalf of several independent channels. Each channel holds a memory address, a byte count and a control word. Software reaches them over a simple register bus, and writing the control word with its enable bit set starts the channel. In the transmit direction the engine reads words from memory and pushes them into the FIFO of the endpoint named in the control word. In the receive direction it pops words from that FIFO and writes them to memory.

One burst sequencer is shared by every channel. A round-robin arbiter hands it one enabled channel at a time. The sequencer sizes a burst from the channel's burst code and its remaining count, then runs the burst beat by beat. On each beat the channel's address moves forward and its count moves down by the number of bytes carried. A channel with a finished transfer or a failed beat raises its bit in a shared status register. Reading that register returns it and clears it, and the interrupt line is the OR of its bits.

The sequencer has four states:
- `SEQ_IDLE` goes to `SEQ_LOAD` when any channel is enabled, and the arbiter's winner is latched at that point.
- `SEQ_LOAD` goes back to `SEQ_IDLE` if the channel has been disabled since it was picked, goes to `SEQ_CLOSE` if its count is zero, and otherwise goes to `SEQ_XFER` with the burst length loaded.
- `SEQ_XFER` goes to `SEQ_IDLE` on an acknowledged beat that carries an error, and goes to `SEQ_CLOSE` on the last good beat.
- `SEQ_CLOSE` reports completion if the channel is still enabled with a zero count, then returns to `SEQ_IDLE`.

Top module: `pkt_dma_engine`

## Requirements
- R1: After reset, every channel's control, address and count registers read zero, the status register reads zero and `irq` is low.
- R2: Channel n's registers are at offsets n*16+0 (control), n*16+4 (address) and n*16+8 (count), and the status register is at NCH*16. Read data appears on `reg_rdata` in the cycle after `reg_rd`. The control word has these fields: bit 0 enable, bit 1 transmit (memory to FIFO), bit 2 mode-1 (stored only), bit 3 interrupt enable, bits 7:4 endpoint, bit 8 bus error, bits 10:9 burst code. Bits 31:11 read back as zero.
- R3: A write to an address register stores the value with its two low bits forced to zero.
- R4: While a channel runs, each acknowledged good beat carries min(4, count) bytes. The address grows and the count shrinks by that amount, so the address read back minus the start address equals the bytes moved. In transmit, memory read data goes to `fifo_push_data` with `fifo_ep` set to the endpoint. In receive, `fifo_pop_data` is written to memory.
- R5: The burst length on `mem_beats` is min(L, ceil(count/4)), where L is 1, 4, 8 or 16 for burst codes 0, 1, 2 and 3.
- R6: A beat with count below 4 enables only its low count byte lanes (`mem_be` = 2^count-1). Full beats use 4'hF.
- R7: Enabled channels are served one burst at a time in ascending order, starting after the channel served last and wrapping. Channel 0 is searched first after reset.
- R8: When a running channel's count reaches zero, its enable clears, and its status bit is set if its interrupt enable is set. A channel started with count zero completes this way without a memory access.
- R9: An acknowledged beat with `mem_err` high ends the burst. It sets the channel's bus-error bit, clears its enable and sets its status bit whatever the interrupt enable is. That beat moves no data to the FIFO and leaves the address and count unchanged.
- R10: A status read returns the bits and clears them, except bits set in that same cycle, which survive. `irq` is high exactly when some status bit is set.
- R11: Writing the control word with enable clear stops a channel after its current burst, with no status bit set. The address and count keep the progress made and can then be written to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | RAW (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| irq | output | 1 | Shared interrupt, OR of the status bits |
| mem_req | output | 1 | Burst in progress, one beat per acknowledge |
| mem_we | output | 1 | 1 = memory write (receive), 0 = read (transmit) |
| mem_addr | output | AW (32) | Word address of the current beat |
| mem_be | output | 4 | Byte lanes of the current beat |
| mem_beats | output | 5 | Length of the current burst |
| mem_wdata | output | 32 | Write data of the current beat |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat accepted |
| mem_err | input | 1 | Bus error on the acknowledged beat |
| fifo_ep | output | 4 | Endpoint of the active channel |
| fifo_push | output | 1 | Transmit word pushed to the endpoint FIFO |
| fifo_push_data | output | 32 | Transmit word |
| fifo_push_be | output | 4 | Valid byte lanes of the transmit word |
| fifo_pop | output | 1 | Receive word taken from the endpoint FIFO |
| fifo_pop_data | input | 32 | Head word of the receive FIFO |

## Verification
The bench builds the engine with its defaults: eight channels and 32-bit addresses and counts. All three register offsets and the status address are therefore reachable, and the round-robin wrap can be exercised across real channel numbers. A 4 KB memory model acknowledges every beat and returns a bus error in one address window. That setup brings a few cases within reach: a transfer ending in a partial word, two channels interleaving single-beat and four-beat bursts, a stop requested in the middle of a sixteen-beat burst, and a zero-length start.

// File: rtl/pkt_dma_pkg.sv
package pkt_dma_pkg;

    typedef enum logic [1:0] {
        BURST_ONE = 2'd0,
        BURST_B4  = 2'd1,
        BURST_B8  = 2'd2,
        BURST_B16 = 2'd3
    } burst_e;

    typedef struct packed {
        burst_e     burst;   // 10:9
        logic       berr;    // 8
        logic [3:0] ep;      // 7:4
        logic       ie;      // 3
        logic       mode1;   // 2
        logic       tx;      // 1
        logic       en;      // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_LOAD  = 2'd1,
        SEQ_XFER  = 2'd2,
        SEQ_CLOSE = 2'd3
    } seq_state_e;

    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_ADDR = 4'h4;
    localparam logic [3:0] OFF_CNT  = 4'h8;

endpackage

// File: rtl/pkt_dma_chan.sv
module pkt_dma_chan
    import pkt_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_wr_ctrl,
    input  logic          sw_wr_addr,
    input  logic          sw_wr_cnt,
    input  logic [31:0]   sw_wdata,
    input  logic          eng_step,
    input  logic [2:0]    eng_bytes,
    input  logic          eng_done,
    input  logic          eng_err,
    output ctrl_t         ctrl_q,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] cnt_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (sw_wr_ctrl) begin
            ctrl_q <= ctrl_t'(sw_wdata[CTRL_W-1:0]);
        end else if (eng_err) begin
            ctrl_q.en   <= 1'b0;
            ctrl_q.berr <= 1'b1;
        end else if (eng_done) begin
            ctrl_q.en <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (sw_wr_addr) begin
            addr_q <= AW'(sw_wdata) & ~AW'(3);
        end else if (eng_step) begin
            addr_q <= addr_q + AW'(eng_bytes);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sw_wr_cnt) begin
            cnt_q <= CW'(sw_wdata);
        end else if (eng_step) begin
            cnt_q <= cnt_q - CW'(eng_bytes);
        end
    end

    // R4: the engine never steps past the remaining count
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        eng_step |-> (CW'(eng_bytes) <= cnt_q));

    // R3: a written address lands word aligned
    a_r3_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_addr |=> (addr_q[1:0] == 2'b00));

    // R9: an error beat leaves the channel stopped and flagged
    a_r9_err_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_err && !sw_wr_ctrl) |=> (!ctrl_q.en && ctrl_q.berr));

    // R8: completion drops the enable
    a_r8_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !sw_wr_ctrl) |=> !ctrl_q.en);

endmodule

// File: rtl/pkt_dma_rr.sv
module pkt_dma_rr #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic [IW-1:0] gidx,
    output logic [N-1:0]  grant
);

    logic [IW-1:0] last_q;
    logic          found;

    always_comb begin
        gidx  = '0;
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last_q) + k) % N;
            if (!found && req[c]) begin
                found = 1'b1;
                gidx  = IW'(c);
            end
        end
        grant = N'(found) << gidx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= IW'(N - 1);
        end else if (take) begin
            last_q <= gidx;
        end
    end

    // R7: at most one channel granted
    a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7: the sequencer only takes a grant when something is requesting
    a_r7_take_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (|req));

endmodule

// File: rtl/pkt_dma_seq.sv
module pkt_dma_seq
    import pkt_dma_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_req,
    input  logic          cur_en,
    input  logic [CW-1:0] cur_cnt,
    input  burst_e        cur_burst,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          take,
    output logic          mem_req,
    output logic [4:0]    mem_beats,
    output logic          beat_ok,
    output logic          beat_err,
    output logic          xfer_done,
    output logic [2:0]    step_bytes,
    output logic [3:0]    step_be
);

    seq_state_e state_q, state_d;
    logic [4:0] left_q;
    logic [4:0] beats_q;
    logic [4:0] lim;
    logic [CW-1:0] words;
    logic [4:0] burst_len;
    logic       cnt_full;

    always_comb begin
        unique case (cur_burst)
            BURST_ONE: lim = 5'd1;
            BURST_B4:  lim = 5'd4;
            BURST_B8:  lim = 5'd8;
            BURST_B16: lim = 5'd16;
            default:   lim = 5'd1;
        endcase
        words     = (cur_cnt >> 2) + CW'(cur_cnt[1:0] != 2'b00);
        burst_len = (words < CW'(lim)) ? words[4:0] : lim;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (any_req) state_d = SEQ_LOAD;
            SEQ_LOAD: begin
                if (!cur_en)            state_d = SEQ_IDLE;
                else if (cur_cnt == '0) state_d = SEQ_CLOSE;
                else                    state_d = SEQ_XFER;
            end
            SEQ_XFER: begin
                if (mem_ack) begin
                    if (mem_err)            state_d = SEQ_IDLE;
                    else if (left_q == 5'd1) state_d = SEQ_CLOSE;
                end
            end
            SEQ_CLOSE: state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            left_q  <= '0;
            beats_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_LOAD) begin
                left_q  <= burst_len;
                beats_q <= burst_len;
            end else if (state_q == SEQ_XFER && mem_ack) begin
                left_q <= left_q - 5'd1;
            end
        end
    end

    always_comb begin
        cnt_full   = (cur_cnt >= CW'(4));
        take       = (state_q == SEQ_IDLE) && any_req;
        mem_req    = (state_q == SEQ_XFER);
        mem_beats  = beats_q;
        beat_ok    = (state_q == SEQ_XFER) && mem_ack && !mem_err;
        beat_err   = (state_q == SEQ_XFER) && mem_ack && mem_err;
        xfer_done  = (state_q == SEQ_CLOSE) && cur_en && (cur_cnt == '0);
        step_bytes = cnt_full ? 3'd4 : {1'b0, cur_cnt[1:0]};
        step_be    = cnt_full ? 4'hF : ((4'b0001 << cur_cnt[1:0]) - 4'b0001);
    end

    // R5: a running burst always has between one and sixteen beats left
    a_r5_beats_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_XFER) |-> (left_q != 5'd0 && left_q <= 5'd16));

endmodule

// File: rtl/pkt_dma_engine.sv
module pkt_dma_engine
    import pkt_dma_pkg::*;
#(
    parameter  int NCH = 8,
    parameter  int AW  = 32,
    parameter  int CW  = 32,
    localparam int CHB = $clog2(NCH),
    localparam int RAW = CHB + 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           irq,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [3:0]     mem_be,
    output logic [4:0]     mem_beats,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    input  logic           mem_ack,
    input  logic           mem_err,
    output logic [3:0]     fifo_ep,
    output logic           fifo_push,
    output logic [31:0]    fifo_push_data,
    output logic [3:0]     fifo_push_be,
    output logic           fifo_pop,
    input  logic [31:0]    fifo_pop_data
);

    localparam logic [RAW-1:0] STAT_ADDR = RAW'(NCH) << 4;

    ctrl_t          ctrl_a [NCH];
    logic [AW-1:0]  addr_a [NCH];
    logic [CW-1:0]  cnt_a  [NCH];
    logic [NCH-1:0] en_vec;
    logic [NCH-1:0] stat_q, stat_set, grant;
    logic [CHB-1:0] gidx, cur_ch, sel;
    logic [3:0]     off;
    logic           is_stat, stat_rd;
    logic           take, beat_ok, beat_err, xfer_done;
    logic [2:0]     step_bytes;
    logic [3:0]     step_be;

    assign sel     = reg_addr[CHB+3:4];
    assign off     = reg_addr[3:0];
    assign is_stat = (reg_addr == STAT_ADDR);
    assign stat_rd = reg_rd && is_stat;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit, in_win;
        assign in_win = !reg_addr[RAW-1] && (sel == CHB'(g));
        assign hit    = (cur_ch == CHB'(g));

        pkt_dma_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .sw_wr_ctrl (reg_wr && in_win && off == OFF_CTRL),
            .sw_wr_addr (reg_wr && in_win && off == OFF_ADDR),
            .sw_wr_cnt  (reg_wr && in_win && off == OFF_CNT),
            .sw_wdata   (reg_wdata),
            .eng_step   (hit && beat_ok),
            .eng_bytes  (step_bytes),
            .eng_done   (hit && xfer_done),
            .eng_err    (hit && beat_err),
            .ctrl_q     (ctrl_a[g]),
            .addr_q     (addr_a[g]),
            .cnt_q      (cnt_a[g])
        );

        assign en_vec[g]   = ctrl_a[g].en;
        assign stat_set[g] = hit && ((xfer_done && ctrl_a[g].ie) || beat_err);
    end

    pkt_dma_rr #(.N(NCH)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (en_vec),
        .take  (take),
        .gidx  (gidx),
        .grant (grant)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cur_ch <= '0;
        else if (take) cur_ch <= gidx;
    end

    pkt_dma_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_req    (|grant),
        .cur_en     (ctrl_a[cur_ch].en),
        .cur_cnt    (cnt_a[cur_ch]),
        .cur_burst  (ctrl_a[cur_ch].burst),
        .mem_ack    (mem_ack),
        .mem_err    (mem_err),
        .take       (take),
        .mem_req    (mem_req),
        .mem_beats  (mem_beats),
        .beat_ok    (beat_ok),
        .beat_err   (beat_err),
        .xfer_done  (xfer_done),
        .step_bytes (step_bytes),
        .step_be    (step_be)
    );

    assign mem_we         = !ctrl_a[cur_ch].tx;
    assign mem_addr       = addr_a[cur_ch] & ~AW'(3);
    assign mem_be         = step_be;
    assign mem_wdata      = fifo_pop_data;
    assign fifo_ep        = ctrl_a[cur_ch].ep;
    assign fifo_push      = beat_ok && ctrl_a[cur_ch].tx;
    assign fifo_push_data = mem_rdata;
    assign fifo_push_be   = step_be;
    assign fifo_pop       = beat_ok && !ctrl_a[cur_ch].tx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_rd ? '0 : stat_q) | stat_set;
    end
    assign irq = |stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (is_stat) begin
                reg_rdata <= 32'(stat_q);
            end else if (reg_addr[RAW-1]) begin
                reg_rdata <= '0;
            end else begin
                case (off)
                    OFF_CTRL: reg_rdata <= 32'(ctrl_a[sel]);
                    OFF_ADDR: reg_rdata <= 32'(addr_a[sel]);
                    OFF_CNT:  reg_rdata <= 32'(cnt_a[sel]);
                    default:  reg_rdata <= '0;
                endcase
            end
        end
    end

    // R10: a status read with nothing new arriving leaves the register empty
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && stat_set == '0) |=> (stat_q == '0 && !irq));

    // R6: every beat on the bus carries at least one byte lane
    a_r6_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be != 4'h0));

endmodule

// File: tb/pkt_dma_engine_test.sv
module pkt_dma_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [4:0]  mem_beats;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [3:0]  fifo_ep, fifo_push_be;
    logic        fifo_push, fifo_pop;
    logic [31:0] fifo_push_data;
    logic [31:0] fifo_pop_data = '0;

    always #2 clk = ~clk;

    pkt_dma_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_beats(mem_beats), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .fifo_ep(fifo_ep), .fifo_push(fifo_push), .fifo_push_data(fifo_push_data),
        .fifo_push_be(fifo_push_be), .fifo_pop(fifo_pop), .fifo_pop_data(fifo_pop_data)
    );

    typedef struct {
        logic [31:0] d;
        logic [3:0]  be;
        logic [3:0]  ep;
    } item_t;

    item_t       sbq[$];
    int          beats_log[$];
    logic [31:0] bmem [0:1023];
    int          checks = 0, fails = 0;
    int          rx_idx = 0;
    bit          pop_seen = 0, req_prev = 0;

    function automatic logic [31:0] rx_pat(int i);
        return 32'h5A00_0000 + 32'(i) * 32'h0001_0203;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model, FIFO source and scoreboard monitor
    initial begin
        for (int i = 0; i < 1024; i++) bmem[i] = 32'hC0DE_0000 ^ (32'(i) * 32'h0001_0001);
        forever begin
            @(negedge clk);
            if (pop_seen) begin rx_idx++; pop_seen = 0; end
            fifo_pop_data = rx_pat(rx_idx);
            mem_ack = 1'b0;
            mem_err = 1'b0;
            if (mem_req) begin
                if (!req_prev) beats_log.push_back(int'(mem_beats));
                mem_ack   = 1'b1;
                mem_err   = (mem_addr[11:8] == 4'hE);
                mem_rdata = bmem[mem_addr[11:2]];
            end
            req_prev = mem_req;
            #1;
            if (mem_ack && !mem_err && mem_we)
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) bmem[mem_addr[11:2]][8*b +: 8] = mem_wdata[8*b +: 8];
            if (fifo_pop) pop_seen = 1;
            if (fifo_push) begin
                if (sbq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R4 unexpected push actual=%h expected=none", fifo_push_data);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    check("R4 push data", fifo_push_data, it.d);
                    check("R6 push byte enables", 32'(fifo_push_be), 32'(it.be));
                    check("R7 push endpoint order", 32'(fifo_ep), 32'(it.ep));
                end
            end
        end
    end

    task automatic rw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rr(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] ra(int ch, int off);
        return 8'(ch * 16 + off);
    endfunction

    task automatic expect_tx(input logic [31:0] start, input int count, input logic [3:0] ep);
        int rem;
        rem = count;
        for (int k = 0; rem > 0; k++) begin
            item_t it;
            it.d  = bmem[start[11:2] + 10'(k)];
            it.be = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
            it.ep = ep;
            sbq.push_back(it);
            rem -= 4;
        end
    endtask

    task automatic wait_irq(input int limit);
        for (int i = 0; i < limit && !irq; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int          base_idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq after reset", 32'(irq), 0);
        rr(8'h80, d); check("R1 status after reset", d, 0);
        rr(ra(0, 0), d); check("R1 ctrl0 after reset", d, 0);
        rr(ra(7, 4), d); check("R1 addr7 after reset", d, 0);
        rr(ra(3, 8), d); check("R1 count3 after reset", d, 0);

        // R2 field readback, R3 alignment
        rw(ra(2, 4), 32'h0000_0103);
        rr(ra(2, 4), d); check("R3 address low bits dropped", d, 32'h100);
        rw(ra(2, 0), 32'hABCD_06F6);
        rr(ra(2, 0), d); check("R2 control readback", d, 32'h6F6);
        rw(ra(2, 0), 0);

        // R4/R5/R6/R8: transmit ch0, 10 bytes, INCR4, ep 3
        beats_log.delete();
        expect_tx(32'h100, 10, 4'd3);
        rw(ra(0, 4), 32'h100);
        rw(ra(0, 8), 10);
        rw(ra(0, 0), 32'h23B);
        wait_irq(100);
        repeat (2) @(negedge clk);
        check("R8 irq on completion", 32'(irq), 1);
        check("R4 scoreboard drained", 32'(sbq.size()), 0);
        check("R5 beats logged", 32'(beats_log.size()), 1);
        if (beats_log.size() > 0) check("R5 beat count ceil(10/4)", 32'(beats_log[0]), 3);
        rr(ra(0, 4), d); check("R4 address minus start equals bytes", d - 32'h100, 10);
        rr(ra(0, 8), d); check("R8 count reaches zero", d, 0);
        rr(ra(0, 0), d); check("R8 enable cleared", d, 32'h23A);
        rr(8'h80, d); check("R8 status bit 0", d, 32'h01);
        rr(8'h80, d); check("R10 status cleared by read", d, 0);
        check("R10 irq low after clear", 32'(irq), 0);

        // R4/R5: receive ch3, 40 bytes, INCR8, ep 5
        beats_log.delete();
        base_idx = rx_idx;
        rw(ra(3, 4), 32'h300);
        rw(ra(3, 8), 40);
        rw(ra(3, 0), 32'h459);
        wait_irq(200);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 10; k++)
            check("R4 receive word in memory", bmem[(32'h300 >> 2) + k], rx_pat(base_idx + k));
        check("R5 receive bursts", 32'(beats_log.size()), 2);
        if (beats_log.size() == 2) begin
            check("R5 first receive burst", 32'(beats_log[0]), 8);
            check("R5 tail receive burst", 32'(beats_log[1]), 2);
        end
        rr(8'h80, d); check("R8 status bit 3", d, 32'h08);

        // R7: round robin between ch1 (single beats) and ch2 (INCR4)
        beats_log.delete();
        begin
            item_t it;
            it.be = 4'hF;
            it.ep = 4'd1; it.d = bmem[32'h200 >> 2]; sbq.push_back(it);
            for (int k = 0; k < 4; k++) begin it.ep = 4'd2; it.d = bmem[(32'h280 >> 2) + k]; sbq.push_back(it); end
            it.ep = 4'd1; it.d = bmem[(32'h200 >> 2) + 1]; sbq.push_back(it);
            for (int k = 4; k < 8; k++) begin it.ep = 4'd2; it.d = bmem[(32'h280 >> 2) + k]; sbq.push_back(it); end
        end
        rw(ra(1, 4), 32'h200); rw(ra(1, 8), 8);
        rw(ra(2, 4), 32'h280); rw(ra(2, 8), 32);
        rw(ra(1, 0), 32'h01B);
        rw(ra(2, 0), 32'h22B);
        repeat (60) @(negedge clk);
        check("R7 scoreboard drained", 32'(sbq.size()), 0);
        check("R7 burst count", 32'(beats_log.size()), 4);
        if (beats_log.size() == 4) begin
            check("R5 single-beat code", 32'(beats_log[0]), 1);
            check("R7 second burst from ch2", 32'(beats_log[1]), 4);
            check("R7 third burst back to ch1", 32'(beats_log[2]), 1);
            check("R7 fourth burst ch2", 32'(beats_log[3]), 4);
        end
        rr(8'h80, d); check("R8 status bits 1 and 2", d, 32'h06);

        // R9: bus error on ch4 with interrupt enable clear
        beats_log.delete();
        rw(ra(4, 4), 32'hE00); rw(ra(4, 8), 8);
        rw(ra(4, 0), 32'h243);
        wait_irq(100);
        rr(ra(4, 0), d); check("R9 error bit set, enable clear", d, 32'h342);
        rr(ra(4, 8), d); check("R9 count untouched", d, 8);
        rr(ra(4, 4), d); check("R9 address untouched", d, 32'hE00);
        rr(8'h80, d); check("R9 status bit 4 despite ie=0", d, 32'h10);

        // R8: zero-length start on ch6
        beats_log.delete();
        rw(ra(6, 0), 32'h009);
        wait_irq(50);
        rr(8'h80, d); check("R8 zero count completes", d, 32'h40);
        check("R8 zero count without memory access", 32'(beats_log.size()), 0);

        // R8: interrupt enable clear on ch7
        expect_tx(32'h380, 4, 4'd7);
        rw(ra(7, 4), 32'h380); rw(ra(7, 8), 4);
        rw(ra(7, 0), 32'h073);
        repeat (30) @(negedge clk);
        check("R8 no irq with ie clear", 32'(irq), 0);
        rr(8'h80, d); check("R8 no status with ie clear", d, 0);
        rr(ra(7, 0), d); check("R8 enable cleared with ie clear", d, 32'h072);
        check("R4 ch7 word pushed", 32'(sbq.size()), 0);

        // R11: stop ch5 receive during first 16-beat burst
        rw(ra(5, 4), 32'h600); rw(ra(5, 8), 32'h100);
        rw(ra(5, 0), 32'h609);
        repeat (6) @(negedge clk);
        rw(ra(5, 0), 0);
        repeat (40) @(negedge clk);
        rr(8'h80, d); check("R11 no status after stop", d, 0);
        rr(ra(5, 0), d); check("R11 control reads stopped", d, 0);
        rr(ra(5, 4), d); check("R11 address after one burst", d, 32'h640);
        rr(ra(5, 8), d); check("R11 count after one burst", d, 32'hC0);
        rw(ra(5, 4), 0); rw(ra(5, 8), 0);
        rr(ra(5, 4), d); check("R11 address cleared", d, 0);
        rr(ra(5, 8), d); check("R11 count cleared", d, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule